// File: doc/BRIEF.md
# Character Display Command Core

This block is the controller-side model of a character display module. A host drives a register-select line, a read/write line, a one-cycle access strobe and an 8-bit data bus. Writes with register-select low are instructions. Writes with register-select high are character or glyph bytes. Reads return either the status word or a RAM byte. The core holds the address counter, the entry mode, the display enable, cursor and blink bits, the interface and line/font bits, and a horizontal shift offset. It also holds an 80-byte character RAM for the visible text and a 64-byte glyph RAM.

Every accepted access other than a status read makes the core busy for a set number of clock cycles. While busy, it ignores everything except status reads. Pixel generation, the font table and the narrow-bus mode are outside this block. The bus8 bit is only stored.

Top module: `charlcd_core`

## Requirements
- R1: After reset, the core is in the following state. The address counter is 0 and busy is clear. The display, cursor and blink are off. The entry mode is increment with no shift. The core is in one-line mode with the short font and the 8-bit flag set, and the shift offset is 0. Every character RAM byte is 0x20 and the read latch holds 0x00.
- R2: An instruction is decoded by its highest set bit, as follows:
  - bit0: clear.
  - bit1: home.
  - bit2: entry mode, with increment in bit1 and shift in bit0.
  - bit3: display control, with display in bit2, cursor in bit1 and blink in bit0.
  - bit4: shift command, with display-not-cursor in bit3 and right in bit2.
  - bit5: function set, with 8-bit in bit4, two-line in bit3 and tall font in bit2.
  - bit6: glyph address in bits 5..0.
  - bit7: character address in bits 6..0.
  - Lower bits outside these fields are ignored.
- R3: Clear writes 0x20 to every character RAM byte. It sets the address counter to 0 and the shift offset to 0. It forces increment mode and leaves the entry shift bit as it is.
- R4: Home sets the address counter and the shift offset to 0 and leaves the RAM contents unchanged.
- R5: Each accepted data write or data read moves the address counter by +1 when increment is set, or by -1 otherwise.
  - A character RAM write with entry shift set also moves the shift offset: +1 in increment mode, -1 in decrement mode.
  - A read never moves the shift offset.
- R6: The address counter wraps as follows:
  - Two-line mode: 0x27 steps up to 0x40 and 0x67 steps up to 0x00. Stepping down mirrors this.
  - One-line mode: 0x4F steps up to 0x00 and 0x00 steps down to 0x4F.
  - Glyph addresses wrap within 6 bits.
- R7: A shift command with display-not-cursor set changes only the shift offset: left is +1 and right is -1, wrapping over 0..39 in two-line mode and 0..79 in one-line mode. With display-not-cursor clear, it moves the address counter one step right or left.
- R8: A status read (register-select 0, read 1) returns busy in bit7 and the address counter in bits 6..0. It is accepted at any time and never starts a busy period.
- R9: Busy lasts LONG_CYC cycles after clear or home and SHORT_CYC cycles after any other accepted access. Busy is counted from the cycle after the strobe. Any non-status access during busy is ignored.
- R10: Instruction 0x00 changes no state but still starts a short busy period.
- R11: A data read returns the read latch and then reloads the latch from RAM at the current address. The first read after an address set therefore returns a stale byte, and consecutive reads return successive locations.
- R12: Function set updates the 8-bit, two-line and tall-font flags and resets the shift offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| en | input | 1 | one-cycle access strobe |
| rs | input | 1 | 1 = data, 0 = instruction/status |
| rw | input | 1 | 1 = read, 0 = write |
| db_in | input | 8 | write data |
| db_out | output | 8 | read data: status word or read latch |
| disp_on | output | 1 | display enabled |
| cursor_on | output | 1 | cursor shown |
| blink_on | output | 1 | cursor cell blinks |
| entry_inc | output | 1 | address counter increments |
| entry_shift | output | 1 | display shifts on writes |
| two_line | output | 1 | two-line address map |
| tall_font | output | 1 | tall font selected |
| bus_8bit | output | 1 | 8-bit interface flag |
| shift_ofs | output | 7 | horizontal display shift offset |

## Verification
The assertions assume the following about the inputs:
- The access strobe lasts one cycle.
- Register-select, read/write and data are valid in the cycle the strobe is high.

The stimulus meets this by driving all inputs on the falling edge and holding the strobe for one cycle only. After each state-changing access it waits longer than the longest busy period. The one exception is where a test deliberately probes busy timing or the rejection of accesses during busy. In those cases status reads and an ignored data write are placed at computed cycle offsets from the strobe.

// File: rtl/charlcd_core.sv
module charlcd_core #(
  parameter int LINE_LEN  = 40,
  parameter int LONG_CYC  = 16,
  parameter int SHORT_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] db_in,
  output logic [7:0] db_out,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       entry_inc,
  output logic       entry_shift,
  output logic       two_line,
  output logic       tall_font,
  output logic       bus_8bit,
  output logic [$clog2(2*LINE_LEN)-1:0] shift_ofs
);
  localparam int DD_SIZE = 2 * LINE_LEN;
  localparam int CG_SIZE = 64;
  localparam int OW = $clog2(DD_SIZE);
  localparam int BW = $clog2(LONG_CYC + 1);
  localparam logic [6:0] L1_END  = 7'(LINE_LEN - 1);
  localparam logic [6:0] L2_BASE = 7'h40;
  localparam logic [6:0] L2_END  = 7'(64 + LINE_LEN - 1);
  localparam logic [6:0] ONE_END = 7'(DD_SIZE - 1);

  typedef enum logic [3:0] {
    C_UNDEF, C_CLEAR, C_HOME, C_ENTRY, C_DISP, C_SHIFT, C_FUNC, C_CG, C_DD
  } cmd_e;

  logic [7:0]    dd [DD_SIZE];
  logic [7:0]    cg [CG_SIZE];
  logic [6:0]    ac;
  logic          cg_sel;
  logic [7:0]    rd_latch;
  logic [BW-1:0] busy_cnt;
  cmd_e          cmd;

  wire busy    = busy_cnt != '0;
  wire accept  = en & ~busy;
  wire instr_wr = accept & ~rs & ~rw;
  wire data_wr  = accept & rs & ~rw;
  wire data_rd  = accept & rs & rw;

  assign db_out = rs ? rd_latch : {busy, ac};

  wire [6:0] dd_ix = two_line ? (ac[6] ? 7'(LINE_LEN) + {1'b0, ac[5:0]} : {1'b0, ac[5:0]}) : ac;
  wire       dd_ok = two_line ? ({1'b0, ac[5:0]} < 7'(LINE_LEN)) : (ac < 7'(DD_SIZE));

  function automatic logic [6:0] step(logic [6:0] a, logic up, logic cgm, logic two);
    if (cgm)
      return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    else if (two) begin
      if (up)  return (a == L1_END) ? L2_BASE : (a == L2_END) ? 7'h00 : a + 7'd1;
      else     return (a == L2_BASE) ? L1_END : (a == 7'h00) ? L2_END : a - 7'd1;
    end else begin
      if (up)  return (a >= ONE_END) ? 7'h00 : a + 7'd1;
      else     return (a == 7'h00) ? ONE_END : a - 7'd1;
    end
  endfunction

  wire [6:0]    ac_mv     = step(ac, entry_inc, cg_sel, two_line);
  wire [6:0]    ac_right  = step(ac, 1'b1, cg_sel, two_line);
  wire [6:0]    ac_left   = step(ac, 1'b0, cg_sel, two_line);
  wire [OW-1:0] span_last = two_line ? OW'(LINE_LEN - 1) : OW'(DD_SIZE - 1);
  wire [OW-1:0] ofs_l     = (shift_ofs == span_last) ? '0 : shift_ofs + 1'b1;
  wire [OW-1:0] ofs_r     = (shift_ofs == '0) ? span_last : shift_ofs - 1'b1;

  always_comb begin
    casez (db_in)
      8'b1???????: cmd = C_DD;
      8'b01??????: cmd = C_CG;
      8'b001?????: cmd = C_FUNC;
      8'b0001????: cmd = C_SHIFT;
      8'b00001???: cmd = C_DISP;
      8'b000001??: cmd = C_ENTRY;
      8'b0000001?: cmd = C_HOME;
      8'b00000001: cmd = C_CLEAR;
      default:     cmd = C_UNDEF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0;  cg_sel <= 1'b0;  rd_latch <= 8'h00;  busy_cnt <= '0;
      entry_inc <= 1'b1;  entry_shift <= 1'b0;
      disp_on <= 1'b0;  cursor_on <= 1'b0;  blink_on <= 1'b0;
      two_line <= 1'b0;  tall_font <= 1'b0;  bus_8bit <= 1'b1;
      shift_ofs <= '0;
      for (int i = 0; i < DD_SIZE; i++) dd[i] <= 8'h20;
      for (int i = 0; i < CG_SIZE; i++) cg[i] <= 8'h00;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (instr_wr) begin
        busy_cnt <= (cmd == C_CLEAR || cmd == C_HOME) ? BW'(LONG_CYC) : BW'(SHORT_CYC);
        case (cmd)
          C_CLEAR: begin
            for (int i = 0; i < DD_SIZE; i++) dd[i] <= 8'h20;
            ac <= '0;  cg_sel <= 1'b0;  shift_ofs <= '0;  entry_inc <= 1'b1;
          end
          C_HOME:  begin ac <= '0;  cg_sel <= 1'b0;  shift_ofs <= '0; end
          C_ENTRY: begin entry_inc <= db_in[1];  entry_shift <= db_in[0]; end
          C_DISP:  begin disp_on <= db_in[2];  cursor_on <= db_in[1];  blink_on <= db_in[0]; end
          C_SHIFT: begin
            if (db_in[3]) shift_ofs <= db_in[2] ? ofs_r : ofs_l;
            else          ac <= db_in[2] ? ac_right : ac_left;
          end
          C_FUNC:  begin
            bus_8bit <= db_in[4];  two_line <= db_in[3];  tall_font <= db_in[2];
            shift_ofs <= '0;
          end
          C_CG:    begin ac <= {1'b0, db_in[5:0]};  cg_sel <= 1'b1; end
          C_DD:    begin ac <= db_in[6:0];  cg_sel <= 1'b0; end
          default: ;
        endcase
      end
      if (data_wr) begin
        busy_cnt <= BW'(SHORT_CYC);
        if (cg_sel)     cg[ac[5:0]] <= db_in;
        else if (dd_ok) dd[dd_ix] <= db_in;
        ac <= ac_mv;
        if (entry_shift && !cg_sel) shift_ofs <= entry_inc ? ofs_l : ofs_r;
      end
      if (data_rd) begin
        busy_cnt <= BW'(SHORT_CYC);
        rd_latch <= cg_sel ? cg[ac[5:0]] : (dd_ok ? dd[dd_ix] : 8'h20);
        ac <= ac_mv;
      end
    end
  end

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && en && !(!rs && rw) |=> $stable(ac) && $stable(shift_ofs)); // R9
  AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BW'(LONG_CYC)); // R9
  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr && db_in == 8'h01 |=> ac == '0 && shift_ofs == '0 && entry_inc && busy); // R3
  AST_HOME_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr && db_in[7:1] == 7'h01 |=> ac == '0 && shift_ofs == '0); // R4
  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr && db_in == 8'h00 |=> $stable(ac) && $stable(shift_ofs) && $stable(entry_inc) && busy); // R10
  AST_STATUS_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    en && !rs && rw && !busy |=> !busy); // R8
  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs <= span_last); // R7
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && two_line && !cg_sel && entry_inc && ac == L1_END |=> ac == L2_BASE); // R6
endmodule

// File: tb/sim_charlcd_core.sv
module sim_charlcd_core;
  localparam int LONG = 16;
  localparam int SHORT = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] db_in = 8'h00, db_out;
  logic disp_on, cursor_on, blink_on, entry_inc, entry_shift, two_line, tall_font, bus_8bit;
  logic [6:0] shift_ofs;
  int checks = 0, errors = 0;

  logic [7:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  charlcd_core #(.LINE_LEN(40), .LONG_CYC(LONG), .SHORT_CYC(SHORT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rs(rs), .rw(rw), .db_in(db_in), .db_out(db_out),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on), .entry_inc(entry_inc),
    .entry_shift(entry_shift), .two_line(two_line), .tall_font(tall_font),
    .bus_8bit(bus_8bit), .shift_ofs(shift_ofs));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic port(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  always @(negedge clk) begin
    #3;
    if (en && rw) begin
      logic [7:0] e;
      bit c;
      string t;
      e = exp_q.pop_front();  c = chk_q.pop_front();  t = tag_q.pop_front();
      if (c) check(db_out == e, t, db_out, e);
    end
  end

  task automatic drive(input logic r_s, input logic r_w, input logic [7:0] d,
                       input logic [7:0] e, input bit c, input string t);
    @(negedge clk);
    rs = r_s;  rw = r_w;  db_in = d;  en = 1'b1;
    if (r_w) begin exp_q.push_back(e);  chk_q.push_back(c);  tag_q.push_back(t); end
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic idle();
    repeat (LONG + 2) @(negedge clk);
  endtask

  task automatic wr_i(input logic [7:0] d); drive(1'b0, 1'b0, d, 8'h00, 1'b0, ""); idle(); endtask
  task automatic wr_d(input logic [7:0] d); drive(1'b1, 1'b0, d, 8'h00, 1'b0, ""); idle(); endtask
  task automatic st(input logic [7:0] e, input string t); drive(1'b0, 1'b1, 8'h00, e, 1'b1, t); endtask
  task automatic rd(input logic [7:0] e, input bit c, input string t);
    drive(1'b1, 1'b1, 8'h00, e, c, t); idle();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    port("R1 disp_on", disp_on, 0);   port("R1 entry_inc", entry_inc, 1);
    port("R1 entry_shift", entry_shift, 0); port("R1 two_line", two_line, 0);
    port("R1 bus_8bit", bus_8bit, 1); port("R1 shift_ofs", shift_ofs, 0);
    st(8'h00, "R1 status");
    rd(8'h00, 1'b1, "R1 latch");
    rd(8'h20, 1'b1, "R1 ram");

    wr_i(8'h38);
    port("R12 two_line", two_line, 1); port("R12 bus_8bit", bus_8bit, 1); port("R12 tall", tall_font, 0);
    wr_i(8'h0F);
    port("R2 disp", disp_on, 1); port("R2 cursor", cursor_on, 1); port("R2 blink", blink_on, 1);
    wr_i(8'h0A);
    port("R2 disp off", disp_on, 0); port("R2 cursor", cursor_on, 1); port("R2 blink off", blink_on, 0);
    wr_i(8'h0C);
    wr_i(8'h06);
    port("R2 entry inc", entry_inc, 1); port("R2 entry shift", entry_shift, 0);

    wr_i(8'hA6);  st(8'h26, "R2 dd addr");
    wr_d(8'h41);  st(8'h27, "R5 inc");
    wr_d(8'h42);  st(8'h40, "R6 wrap up line1");
    wr_d(8'h43);  st(8'h41, "R5 inc");

    wr_i(8'hA6);
    rd(8'h00, 1'b0, "");
    rd(8'h41, 1'b1, "R11 read1");
    rd(8'h42, 1'b1, "R11 read2");
    rd(8'h43, 1'b1, "R11 read3");
    st(8'h42, "R5 read moves ac");
    port("R5 no shift", shift_ofs, 0);

    wr_i(8'h04);
    wr_i(8'hC0);  wr_d(8'h44);  st(8'h27, "R6 wrap down line2");
    wr_i(8'h80);  wr_d(8'h45);  st(8'h67, "R6 wrap down line1");

    wr_i(8'h07);  wr_i(8'h80);
    wr_d(8'h46);  port("R5 shift on write", shift_ofs, 1);  st(8'h01, "R5 ac");
    rd(8'h00, 1'b0, "");  port("R5 read no shift", shift_ofs, 1);
    wr_i(8'h05);
    wr_d(8'h47);  port("R5 shift right", shift_ofs, 0);  st(8'h01, "R5 dec");

    wr_i(8'h18);  port("R7 shift left", shift_ofs, 1);  st(8'h01, "R7 ac kept");
    wr_i(8'h1C);  port("R7 shift right", shift_ofs, 0);
    wr_i(8'h1C);  port("R7 wrap", shift_ofs, 39);
    wr_i(8'h14);  st(8'h02, "R7 cursor right");
    wr_i(8'h10);  st(8'h01, "R7 cursor left");

    drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "");
    repeat (SHORT - 2) @(negedge clk);
    st(8'h81, "R10 busy last cycle");
    idle();
    drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, "");
    repeat (SHORT - 1) @(negedge clk);
    st(8'h01, "R9 short done");
    port("R10 ofs kept", shift_ofs, 39);
    port("R10 entry kept", entry_inc, 0);
    idle();

    drive(1'b0, 1'b0, 8'h03, 8'h00, 1'b0, "");
    repeat (LONG - 2) @(negedge clk);
    st(8'h80, "R9 long busy");
    st(8'h00, "R9 long done");
    port("R4 ofs", shift_ofs, 0);
    idle();
    wr_i(8'hA6);  rd(8'h00, 1'b0, "");  rd(8'h41, 1'b1, "R4 ram kept");

    drive(1'b0, 1'b0, 8'h01, 8'h00, 1'b0, "");
    drive(1'b1, 1'b0, 8'h5A, 8'h00, 1'b0, "");
    idle();
    st(8'h00, "R3 ac");
    port("R3 inc forced", entry_inc, 1);  port("R3 shift kept", entry_shift, 1);
    port("R3 ofs", shift_ofs, 0);
    wr_i(8'h80);  rd(8'h00, 1'b0, "");  rd(8'h20, 1'b1, "R9 ignored write / R3 fill");
    wr_i(8'hC0);  rd(8'h00, 1'b0, "");  rd(8'h20, 1'b1, "R3 fill line2");

    st(8'h42, "R8 status");
    st(8'h42, "R8 status again");

    wr_i(8'h06);  wr_i(8'h30);
    port("R12 one line", two_line, 0);
    wr_i(8'hCF);  wr_d(8'h31);  st(8'h00, "R6 one-line up");
    wr_i(8'h04);  wr_d(8'h32);  st(8'h4F, "R6 one-line down");

    wr_i(8'h06);  wr_i(8'h7F);  wr_d(8'h1F);  st(8'h00, "R6 glyph wrap");
    wr_i(8'h7F);  rd(8'h00, 1'b0, "");  rd(8'h1F, 1'b1, "R11 glyph read");

    wr_i(8'h18);  port("R7 one-line shift", shift_ofs, 1);
    wr_i(8'h3F);
    port("R12 ofs reset", shift_ofs, 0);  port("R12 tall", tall_font, 1);
    port("R12 two_line", two_line, 1);

    finish_run();
  end
endmodule